// File: doc/BRIEF.md
# Master-Slave Gated Timer Pair

Two up-counting timers share one clock. Each has its own clock divider and its own wrap value. The first timer, the master, drives an internal trigger line. A select field in the master control register picks what goes onto that line. It can carry the master's run bit, so the line is high whenever the master is running. It can instead carry a compare level that goes high when the master count reaches a compare value and falls when the count wraps. That second choice gives a PWM-shaped gate.

The second timer, the slave, can take that line as its trigger input. In pause mode, the slave counts only while the trigger is high. While the trigger is low, the slave's count and its divider phase are both frozen, not cleared. A sticky flag records each rising edge of the slave's trigger input, and software clears it by writing zero to it.

Software programs the pair through a single-cycle write port. The two counts and the flag are visible at all times on output ports.

Top module: `gated_timer_pair`

## Requirements
- R1: After reset, both counts are 0 and the trigger flag is 0. Reset leaves the run bits clear, the dividers at 0 and both wrap values all ones.
- R2: The master counter register is at address 0, with the run bit at bit 0. Its divider value is at address 3 and its wrap value at address 4. While running, the master count advances once every divider+1 clocks and returns to 0 on the advance after it equals the wrap value. While stopped, it holds its value.
- R3: The trigger-out select field sits at bits 6:4 of address 0. Value 001 routes the master run bit to the trigger line. The line is registered once, so a paused slave starts or stops counting one clock after the run bit changes.
- R4: Trigger-out select 100 routes the compare level instead. The compare value is at address 2. The level is high while master count ≥ compare value, so it rises when the count equals the compare value and falls at the wrap. Any other select value keeps the line low.
- R5: The slave divider value is at address 5, and the slave count advances once every divider+1 gated clocks. While the slave is gated off, the divider phase is held, so counting resumes mid-period.
- R6: The slave wrap value is at address 6. The slave count returns to 0 on the advance after it equals that value.
- R7: Slave control is at address 1, with the run bit at bit 0. While that bit is 0, the slave count does not change, whatever the trigger does.
- R8: The slave trigger-source field is at bits 10:8 of address 1. Only value 000 connects the master trigger line. With any other source in pause mode, the slave never counts.
- R9: The flag, read on trig_flag, sets on the clock after a rising edge of the slave trigger input. If the master is started by a write at edge k with select 001, the flag reads 1 after edge k+2.
- R10: A write to address 7 with bit 0 = 0 clears the flag. A write there with bit 0 = 1 has no effect. A rising edge in the same cycle as a clear wins.
- R11: The slave mode field is at bits 6:4 of address 1. Value 101 is pause mode. With any other value, the slave counts whenever its run bit is set, ignoring the trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, taken on the rising clock edge |
| wr_addr | input | 3 | Register address |
| wr_data | input | DATA_W | Register write data |
| m_count | output | CNT_W | Master counter value |
| s_count | output | CNT_W | Slave counter value |
| trig_flag | output | 1 | Sticky trigger-rise flag |

## Verification
Every result is timed from the edge that accepts the write that started it. A master run-bit change shows on the master count at once and on a paused slave one clock later. The first slave advance therefore lands divider+2 clocks after the start write, and the flag appears two clocks after it. In compare-level mode, the slave count at cycle T equals the number of cycles up to T−2 in which the master count was at or above the compare value. The scoreboard labels each expected value with its absolute cycle number. The monitor pops each one only in that cycle, on the falling edge, and counts any entry whose cycle has passed as a failure.

// File: rtl/gtp_pkg.sv
package gtp_pkg;
  localparam int unsigned ADDR_W = 3;

  // register addresses
  localparam logic [ADDR_W-1:0] A_MCTL = 3'd0;
  localparam logic [ADDR_W-1:0] A_SCTL = 3'd1;
  localparam logic [ADDR_W-1:0] A_MCMP = 3'd2;
  localparam logic [ADDR_W-1:0] A_MPSC = 3'd3;
  localparam logic [ADDR_W-1:0] A_MARR = 3'd4;
  localparam logic [ADDR_W-1:0] A_SPSC = 3'd5;
  localparam logic [ADDR_W-1:0] A_SARR = 3'd6;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd7;

  // field positions inside control words
  localparam int unsigned RUN_BIT  = 0;
  localparam int unsigned FLD_LSB  = 4;   // trigger-out select / slave mode
  localparam int unsigned SRC_LSB  = 8;   // slave trigger source
  localparam int unsigned FLD_W    = 3;

  // field encodings
  localparam logic [FLD_W-1:0] TRGO_ENABLE = 3'b001;
  localparam logic [FLD_W-1:0] TRGO_CMPREF = 3'b100;
  localparam logic [FLD_W-1:0] SMODE_PAUSE = 3'b101;
  localparam logic [FLD_W-1:0] TSRC_MASTER = 3'b000;

  typedef struct packed {
    logic [FLD_W-1:0] sel;
    logic             run;
  } mctl_t;

  typedef struct packed {
    logic [FLD_W-1:0] src;
    logic [FLD_W-1:0] mode;
    logic             run;
  } sctl_t;
endpackage

// File: rtl/gtp_timer_core.sv
module gtp_timer_core #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             tick_o
);
  logic [PSC_W-1:0] div_q;

  // divider period ends when phase reaches the programmed value
  function automatic logic period_done(input logic [PSC_W-1:0] ph,
                                       input logic [PSC_W-1:0] lim);
    return ph >= lim;
  endfunction

  // wrap to zero once the reload value has been reached
  function automatic logic [CNT_W-1:0] advance(input logic [CNT_W-1:0] c,
                                               input logic [CNT_W-1:0] r);
    return (c >= r) ? '0 : c + 1'b1;
  endfunction

  assign tick_o = run_i && period_done(div_q, psc_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= '0;
      count_o <= '0;
    end else if (run_i) begin
      if (tick_o) begin
        div_q   <= '0;
        count_o <= advance(count_o, reload_i);
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> $stable(count_o));
  assert_phase_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> $stable(div_q));
  assert_no_step_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_i && !tick_o |=> $stable(count_o));
endmodule

// File: rtl/gtp_trig_route.sv
module gtp_trig_route
  import gtp_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             m_run_i,
  input  logic [CNT_W-1:0] m_count_i,
  input  logic [CNT_W-1:0] m_cmp_i,
  input  logic [FLD_W-1:0] sel_i,
  output logic             cmp_ref_o,
  output logic             trig_o
);
  logic trgo_w;

  // level is high from the compare match up to the wrap
  function automatic logic ref_level(input logic [CNT_W-1:0] c,
                                     input logic [CNT_W-1:0] cmp);
    return c >= cmp;
  endfunction

  assign cmp_ref_o = ref_level(m_count_i, m_cmp_i);

  always_comb begin
    unique case (sel_i)
      TRGO_ENABLE: trgo_w = m_run_i;
      TRGO_CMPREF: trgo_w = cmp_ref_o;
      default:     trgo_w = 1'b0;
    endcase
  end

  // single register on the hop from master to slave
  always_ff @(posedge clk) begin
    if (!rst_n) trig_o <= 1'b0;
    else        trig_o <= trgo_w;
  end

  assert_enable_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == TRGO_ENABLE) && m_run_i |=> trig_o);
  assert_ref_low_below_cmp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == TRGO_CMPREF) && (m_count_i < m_cmp_i) |=> !trig_o);
  assert_other_sel_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i != TRGO_CMPREF) && (sel_i != TRGO_ENABLE) |=> !trig_o);
endmodule

// File: rtl/gtp_slave_gate.sv
module gtp_slave_gate
  import gtp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_run_i,
  input  logic [FLD_W-1:0] mode_i,
  input  logic [FLD_W-1:0] src_i,
  input  logic             trig_i,
  input  logic             flag_clr_i,
  output logic             trig_in_o,
  output logic             trig_rise_o,
  output logic             gate_o,
  output logic             flag_o
);
  logic trig_prev_q;

  assign trig_in_o   = (src_i == TSRC_MASTER) && trig_i;
  assign trig_rise_o = trig_in_o && !trig_prev_q;
  assign gate_o      = s_run_i && ((mode_i == SMODE_PAUSE) ? trig_in_o : 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_prev_q <= 1'b0;
      flag_o      <= 1'b0;
    end else begin
      trig_prev_q <= trig_in_o;
      if (trig_rise_o)     flag_o <= 1'b1;
      else if (flag_clr_i) flag_o <= 1'b0;
    end
  end

  assert_flag_on_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_rise_o |=> flag_o);
  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr_i && !trig_rise_o |=> !flag_o);
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o && !flag_clr_i |=> flag_o);
endmodule

// File: rtl/gated_timer_pair.sv
module gated_timer_pair
  import gtp_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PSC_W  = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  m_count,
  output logic [CNT_W-1:0]  s_count,
  output logic              trig_flag
);
  localparam logic [CNT_W-1:0] RELOAD_RST = {CNT_W{1'b1}};

  mctl_t            mctl_q;
  sctl_t            sctl_q;
  logic [CNT_W-1:0] m_cmp_q, m_arr_q, s_arr_q;
  logic [PSC_W-1:0] m_psc_q, s_psc_q;

  // named internal events
  logic m_tick_w, s_tick_w, cmp_ref_w, trig_q_w;
  logic trig_in_w, trig_rise_w, s_gate_w, flag_clr_w;

  function automatic logic hit(input logic [ADDR_W-1:0] a);
    return wr_en && (wr_addr == a);
  endfunction

  assign flag_clr_w = hit(A_STAT) && !wr_data[RUN_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mctl_q  <= '0;
      sctl_q  <= '0;
      m_cmp_q <= '0;
      m_psc_q <= '0;
      s_psc_q <= '0;
      m_arr_q <= RELOAD_RST;
      s_arr_q <= RELOAD_RST;
    end else begin
      if (hit(A_MCTL)) begin
        mctl_q.run <= wr_data[RUN_BIT];
        mctl_q.sel <= wr_data[FLD_LSB +: FLD_W];
      end
      if (hit(A_SCTL)) begin
        sctl_q.run  <= wr_data[RUN_BIT];
        sctl_q.mode <= wr_data[FLD_LSB +: FLD_W];
        sctl_q.src  <= wr_data[SRC_LSB +: FLD_W];
      end
      if (hit(A_MCMP)) m_cmp_q <= wr_data[CNT_W-1:0];
      if (hit(A_MPSC)) m_psc_q <= wr_data[PSC_W-1:0];
      if (hit(A_MARR)) m_arr_q <= wr_data[CNT_W-1:0];
      if (hit(A_SPSC)) s_psc_q <= wr_data[PSC_W-1:0];
      if (hit(A_SARR)) s_arr_q <= wr_data[CNT_W-1:0];
    end
  end

  gtp_timer_core #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_master (
    .clk(clk), .rst_n(rst_n), .run_i(mctl_q.run), .psc_i(m_psc_q),
    .reload_i(m_arr_q), .count_o(m_count), .tick_o(m_tick_w)
  );

  gtp_trig_route #(.CNT_W(CNT_W)) u_route (
    .clk(clk), .rst_n(rst_n), .m_run_i(mctl_q.run), .m_count_i(m_count),
    .m_cmp_i(m_cmp_q), .sel_i(mctl_q.sel), .cmp_ref_o(cmp_ref_w), .trig_o(trig_q_w)
  );

  gtp_slave_gate u_gate (
    .clk(clk), .rst_n(rst_n), .s_run_i(sctl_q.run), .mode_i(sctl_q.mode),
    .src_i(sctl_q.src), .trig_i(trig_q_w), .flag_clr_i(flag_clr_w),
    .trig_in_o(trig_in_w), .trig_rise_o(trig_rise_w), .gate_o(s_gate_w),
    .flag_o(trig_flag)
  );

  gtp_timer_core #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_slave (
    .clk(clk), .rst_n(rst_n), .run_i(s_gate_w), .psc_i(s_psc_q),
    .reload_i(s_arr_q), .count_o(s_count), .tick_o(s_tick_w)
  );

  assert_pause_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sctl_q.mode == SMODE_PAUSE) && !trig_in_w |=> $stable(s_count));
  assert_slave_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sctl_q.run |=> $stable(s_count));
  assert_foreign_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sctl_q.src != TSRC_MASTER) && (sctl_q.mode == SMODE_PAUSE) |=> $stable(s_count));
  assert_tick_implies_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    s_tick_w |-> sctl_q.run);
  assert_master_tick_needs_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m_tick_w |-> mctl_q.run);
endmodule

// File: tb/test_gated_timer_pair.sv
module test_gated_timer_pair;
  localparam int K_S = 0, K_FLAG = 1, K_M = 2;

  typedef struct {
    int    at;
    int    kind;
    int    val;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] m_count, s_count;
  logic        trig_flag;

  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  exp_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gated_timer_pair i_gated_timer_pair (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .m_count(m_count), .s_count(s_count), .trig_flag(trig_flag)
  );

  function automatic void chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endfunction

  // monitor: pops expectations in their own cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      int   act;
      e = q.pop_front();
      case (e.kind)
        K_S:     act = int'(s_count);
        K_FLAG:  act = int'(trig_flag);
        default: act = int'(m_count);
      endcase
      if (e.at < cyc) begin
        checks++;
        failures++;
        $display("FAIL %s missed cycle %0d: actual=%0d expected=%0d", e.tag, e.at, act, e.val);
      end else begin
        chk(e.tag, act, e.val);
      end
    end
  end

  task automatic push(int at, int kind, int val, string tag);
    exp_t e;
    e.at = at; e.kind = kind; e.val = val; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, output int c);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    c = cyc;
  endtask

  task automatic drain();
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_all();
    int c0, c1, c2, cw, k, acc;
    // ---- reset state
    do_reset();
    chk("R1 m_count", int'(m_count), 0);
    chk("R1 s_count", int'(s_count), 0);
    chk("R1 flag", int'(trig_flag), 0);

    // ---- scenario A: enable gating, slave divider 3
    wr(3'd5, 16'd2, cw);
    wr(3'd6, 16'd100, cw);
    wr(3'd1, 16'h0051, cw);
    wr(3'd3, 16'd0, cw);
    wr(3'd4, 16'd1000, cw);
    wr(3'd0, 16'h0011, c0);
    push(c0 + 1, K_S, 0, "R3 slave idle before trigger");
    push(c0 + 1, K_FLAG, 0, "R9 flag not yet");
    push(c0 + 2, K_FLAG, 1, "R9 flag set");
    for (int n = 1; n <= 4; n++) begin
      push(c0 + 3 * n, K_S, n - 1, "R5 before slave step");
      push(c0 + 1 + 3 * n, K_S, n, "R3 slave step");
      if (n == 2) push(c0 + 7, K_M, 7, "R2 master count");
    end
    drain();
    repeat (2) @(negedge clk);
    wr(3'd0, 16'h0010, c1);
    push(c1 + 1, K_S, (c1 - c0) / 3, "R3 slave frozen");
    push(c1 + 3, K_M, c1 - c0, "R2 master held");
    push(c1 + 5, K_S, (c1 - c0) / 3, "R3 slave still frozen");
    drain();
    wr(3'd7, 16'h0001, cw);
    push(cw, K_FLAG, 1, "R10 write one ignored");
    drain();
    wr(3'd7, 16'h0000, cw);
    push(cw, K_FLAG, 0, "R10 flag cleared");
    drain();
    wr(3'd0, 16'h0011, c2);
    for (int t = c2 + 1; t <= c2 + 8; t++) begin
      k = (c1 - c0) + (t - (c2 + 1));
      push(t, K_S, k / 3, "R5 phase resumes");
      if (t == c2 + 2) push(t, K_FLAG, 1, "R9 flag set again");
    end
    drain();

    // ---- scenario B: compare-level gate
    do_reset();
    wr(3'd5, 16'd0, cw);
    wr(3'd6, 16'd255, cw);
    wr(3'd1, 16'h0051, cw);
    wr(3'd4, 16'd9, cw);
    wr(3'd2, 16'd6, cw);
    wr(3'd0, 16'h0041, c0);
    for (int t = c0 + 1; t <= c0 + 30; t++) begin
      acc = 0;
      for (int u = c0; u <= t - 2; u++) if ((u - c0) % 10 >= 6) acc++;
      push(t, K_M, (t - c0) % 10, "R2 master wrap");
      push(t, K_S, acc, "R4 compare gate");
    end
    drain();

    // ---- scenario C: slave run bit, foreign source, free mode
    do_reset();
    wr(3'd1, 16'h0050, cw);
    wr(3'd0, 16'h0011, c0);
    push(c0 + 10, K_S, 0, "R7 slave run bit clear");
    drain();
    wr(3'd1, 16'h0151, c1);
    push(c1 + 10, K_S, 0, "R8 foreign source");
    drain();
    wr(3'd1, 16'h0001, c2);
    push(c2 + 1, K_S, 1, "R11 free count first");
    push(c2 + 4, K_S, 4, "R11 free count");
    drain();

    // ---- scenario D: slave wrap
    do_reset();
    wr(3'd6, 16'd3, cw);
    wr(3'd1, 16'h0051, cw);
    wr(3'd0, 16'h0011, c0);
    for (int t = c0 + 1; t <= c0 + 10; t++)
      push(t, K_S, (t - c0 - 1) % 4, "R6 slave wrap");
    drain();
  endtask

  initial begin
    bit timed_out;
    timed_out = 1'b0;
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule